// File: doc/BRIEF.md
# Linked-Descriptor DMA Sequencer

A single-channel byte mover that works through a chain of descriptors without help from a processor. A start pulse hands it the index of the first descriptor. The block then fetches each 128-bit descriptor from a small descriptor table, acts on it and follows the chain until a descriptor marked as final has finished. A descriptor is one of four kinds. A copy moves a run of bytes, either ascending or in reversed order. A compare reads one byte of a polled location, tests it under a mask and picks one of two successors. A call jumps to a shared descriptor sequence and records where to come back to. A return resumes at that recorded point.

All data traffic goes through one byte-wide memory port with a valid/ready request side. The block raises `mem_valid` and holds the address, the direction (`mem_we`) and the write byte unchanged until `mem_ready` is seen high at a clock edge. After a read is accepted, no further request is made until `rsp_valid` returns the byte, so at most one read is outstanding. `rsp_valid` is ignored while no read is pending. There is no back-pressure on the response side. The memory may stall any request for any number of cycles.

Descriptor layout: word 0 (bits 31:0) is control, and words 1 to 3 sit at bits 63:32, 95:64 and 127:96. Control word fields: kind in [1:0] (0 copy, 1 compare, 2 call, 3 return), reverse flag in [2], final flag in [3], successor index at bit 8 and up, alternate (branch/call target) index at bit 16 and up.

Top module: `ldq_dma_seq`

## Requirements
- R1: In reset, `busy`, `done`, `err` and `mem_valid` are low. A `start` seen at a clock edge while idle begins fetching at `head_ptr`, and `busy` is high from the following cycle. A `start` seen while `busy` is high has no effect.
- R2: A copy (kind 0, reverse flag 0) with source in word 1, destination in word 2 and byte count in word 3 writes byte i of the source to destination+i for i ascending. Any start address and any count are allowed.
- R3: A copy with the reverse flag (control bit 2) set writes source byte count-1-i to destination+i, so the destination holds the source in reversed order.
- R4: A copy whose count is zero makes no memory request and moves on to its successor.
- R5: A compare (kind 1) reads one byte at the address in word 1. If the byte equals the low byte of word 3 in every bit set in the low byte of word 2, the next descriptor is the alternate index. Otherwise it is the successor index.
- R6: A call (kind 2) continues at its alternate index and records its successor index. A return (kind 3) continues at the recorded index and frees the record, so a later call is accepted.
- R7: A call while a record is held, or a return with none held, sets `err` and stops (`busy` low, no `done`). An accepted `start` clears `err` and the record.
- R8: `done` is a one-cycle pulse, raised after a copy or compare with the final flag (control bit 3) completes. `busy` is low in that cycle, and a `start` in that same cycle is accepted. The final flag is ignored on call and return.
- R9: While `mem_valid` is high and `mem_ready` low, the address, `mem_we` and `mem_wdata` stay stable. Each accepted write carries a byte obtained by the read before it, and each byte is written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| head_ptr | input | PW | Index of first descriptor |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle end-of-chain pulse |
| err | output | 1 | Call/return fault, held until next start |
| dsc_ptr | output | PW | Descriptor table index being read |
| dsc_word | input | 128 | Descriptor at `dsc_ptr`, valid in the same cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| rsp_valid | input | 1 | Read byte returned |
| rsp_data | input | 8 | Read byte |

## Verification
The end-of-chain pulse and the acceptance of a new start can land on the same edge. The bench raises `start` with a new head in the very cycle it sees `done`. It then judges that `busy` was low then and high one cycle later, and that the second chain's reversed bytes all arrive. A second collision is a memory stall against a request: a pseudo-random ready and a one- or two-cycle read latency stretch every transfer. A scoreboard checks each accepted write against the queued expectation, and the bench counts any request that changed while stalled.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  typedef enum logic [1:0] {
    K_COPY = 2'd0,
    K_CMP  = 2'd1,
    K_CALL = 2'd2,
    K_RET  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_RD, S_RWAIT, S_WR, S_NEXT
  } state_e;

  localparam int unsigned DSC_W     = 128;
  localparam int unsigned NEXT_LSB  = 8;
  localparam int unsigned TGT_LSB   = 16;
  localparam int unsigned W1_LSB    = 32;
  localparam int unsigned W2_LSB    = 64;
  localparam int unsigned W3_LSB    = 96;
endpackage

// File: rtl/ldq_walker.sv
module ldq_walker #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          rev,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  input  logic          step,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic          last_one
);
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] rem;
  logic          rev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      rem   <= '0;
      rev_q <= 1'b0;
    end else if (load) begin
      rptr  <= rev ? src + AW'(cnt) - AW'(1) : src;
      wptr  <= dst;
      rem   <= cnt;
      rev_q <= rev;
    end else if (step) begin
      rptr  <= rev_q ? rptr - AW'(1) : rptr + AW'(1);
      wptr  <= wptr + AW'(1);
      rem   <= rem - CW'(1);
    end
  end

  assign rd_addr  = rptr;
  assign wr_addr  = wptr;
  assign last_one = (rem == CW'(1));

  p_step_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> rem != '0);
endmodule

// File: rtl/ldq_link.sv
module ldq_link #(
  parameter int unsigned PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [PW-1:0] push_ptr,
  input  logic          pop,
  output logic          pending,
  output logic [PW-1:0] ret_ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      ret_ptr <= '0;
    end else if (clear) begin
      pending <= 1'b0;
    end else if (push) begin
      pending <= 1'b1;
      ret_ptr <= push_ptr;
    end else if (pop) begin
      pending <= 1'b0;
    end
  end

  p_single_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !pending);
  p_pop_has_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> pending);
endmodule

// File: rtl/ldq_dma_seq.sv
module ldq_dma_seq
  import ldq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] head_ptr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [PW-1:0] dsc_ptr,
  input  logic [127:0]  dsc_word,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data
);
  state_e           st;
  logic [DSC_W-1:0] d;
  logic [PW-1:0]    nxt;
  logic [7:0]       byte_q;
  kind_e            kind;
  logic             rev, fin, start_acc, copy_zero, hit;
  logic [PW-1:0]    f_next, f_tgt, ret_ptr;
  logic             pending, push, pop, w_load, w_step, last_one;
  logic [AW-1:0]    rd_addr, wr_addr;
  logic             unused_dsc;

  assign kind      = kind_e'(d[1:0]);
  assign rev       = d[2];
  assign fin       = d[3] && !d[1];
  assign f_next    = d[NEXT_LSB +: PW];
  assign f_tgt     = d[TGT_LSB +: PW];
  assign copy_zero = (d[W3_LSB +: CW] == '0);
  assign hit       = (((rsp_data ^ d[W3_LSB +: 8]) & d[W2_LSB +: 8]) == 8'h00);
  assign start_acc = (st == S_IDLE) && start;
  assign unused_dsc = ^d;

  assign w_load = (st == S_EXEC) && (kind == K_COPY);
  assign w_step = (st == S_WR) && mem_ready;
  assign push   = (st == S_EXEC) && (kind == K_CALL) && !pending;
  assign pop    = (st == S_EXEC) && (kind == K_RET) && pending;

  ldq_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(w_load), .rev(rev),
    .src(d[W1_LSB +: AW]), .dst(d[W2_LSB +: AW]), .cnt(d[W3_LSB +: CW]),
    .step(w_step), .rd_addr(rd_addr), .wr_addr(wr_addr), .last_one(last_one)
  );

  ldq_link #(.PW(PW)) u_link (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .push(push),
    .push_ptr(f_next), .pop(pop), .pending(pending), .ret_ptr(ret_ptr)
  );

  assign busy      = (st != S_IDLE);
  assign mem_valid = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_wdata = byte_q;
  always_comb begin
    if (st == S_WR)          mem_addr = wr_addr;
    else if (kind == K_COPY) mem_addr = rd_addr;
    else                     mem_addr = d[W1_LSB +: AW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      d       <= '0;
      nxt     <= '0;
      byte_q  <= '0;
      dsc_ptr <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          dsc_ptr <= head_ptr;
          err     <= 1'b0;
          st      <= S_FETCH;
        end
        S_FETCH: begin
          d  <= dsc_word;
          st <= S_EXEC;
        end
        S_EXEC: begin
          unique case (kind)
            K_COPY: begin
              nxt <= f_next;
              st  <= copy_zero ? S_NEXT : S_RD;
            end
            K_CMP: begin
              nxt <= f_next;
              st  <= S_RD;
            end
            K_CALL: if (pending) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else begin
              nxt <= f_tgt;
              st  <= S_NEXT;
            end
            K_RET: if (!pending) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else begin
              nxt <= ret_ptr;
              st  <= S_NEXT;
            end
          endcase
        end
        S_RD: if (mem_ready) st <= S_RWAIT;
        S_RWAIT: if (rsp_valid) begin
          if (kind == K_COPY) begin
            byte_q <= rsp_data;
            st     <= S_WR;
          end else begin
            if (hit) nxt <= f_tgt;
            st <= S_NEXT;
          end
        end
        S_WR: if (mem_ready) st <= last_one ? S_NEXT : S_RD;
        S_NEXT: begin
          if (fin) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            dsc_ptr <= nxt;
            st      <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_read_before_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_ready |=> !(mem_valid && mem_we));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !err);
  p_err_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
  p_write_only_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> kind == K_COPY);
endmodule

// File: tb/ldq_dma_seq_test.sv
`timescale 1ns/1ps
module ldq_dma_seq_test;
  localparam int AW = 16, CW = 16, PW = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PW-1:0] head = '0;
  logic busy, done, err, mem_valid, mem_we, mem_ready = 1'b1, rsp_valid = 1'b0;
  logic [PW-1:0] dsc_ptr;
  logic [127:0] dsc_word;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, rsp_data = '0;

  logic [127:0] dtab [64];
  logic [7:0]   mem  [256];
  logic [15:0]  qa[$];
  logic [7:0]   qd[$];
  int n_chk = 0, n_fail = 0, n_acc = 0, n_wr = 0, hold_bad = 0;
  string cur_req = "R2";
  bit saw_done, saw_err, busy_after, err_after;

  always #2.5 clk = ~clk;
  assign dsc_word = dtab[dsc_ptr];

  ldq_dma_seq #(.AW(AW), .CW(CW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head), .busy(busy),
    .done(done), .err(err), .dsc_ptr(dsc_ptr), .dsc_word(dsc_word),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  function automatic logic [127:0] mkd(input logic [1:0] k, input bit rv, input bit fl,
      input logic [5:0] nx, input logic [5:0] tg, input logic [31:0] w1, w2, w3);
    return {w3, w2, w1, 8'h00, 2'b00, tg, 2'b00, nx, 4'h0, fl, rv, k};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_copy(input int src, input int dst, input int cnt, input bit rv);
    for (int i = 0; i < cnt; i++) begin
      qa.push_back(16'(dst + i));
      qd.push_back(rv ? mem[(src + cnt - 1 - i) & 255] : mem[(src + i) & 255]);
    end
  endtask

  task automatic wait_end(input int cap);
    saw_done = 0; saw_err = 0;
    for (int i = 0; i < cap && !saw_done && !saw_err; i++) begin
      @(negedge clk);
      if (done) saw_done = 1;
      if (err && !busy) saw_err = 1;
    end
  endtask

  task automatic run_list(input logic [5:0] h);
    @(negedge clk); head = h; start = 1'b1;
    @(negedge clk); start = 1'b0; busy_after = busy; err_after = err;
    wait_end(3000);
  endtask

  // memory model and write scoreboard monitor
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit rd_pend = 0, prev_stall = 0, prev_we = 0;
    int rd_wait = 0;
    logic [7:0] rd_a = '0;
    logic [15:0] prev_addr = '0;
    logic [7:0] prev_wd = '0;
    forever begin
      @(posedge clk);
      if (prev_stall && (!mem_valid || mem_addr != prev_addr || mem_we != prev_we || mem_wdata != prev_wd))
        hold_bad++;
      prev_stall = mem_valid && !mem_ready;
      prev_addr = mem_addr; prev_we = mem_we; prev_wd = mem_wdata;
      rsp_valid <= 1'b0;
      if (rd_pend) begin
        if (rd_wait == 0) begin
          rsp_valid <= 1'b1; rsp_data <= mem[rd_a]; rd_pend = 0;
        end else rd_wait--;
      end
      if (mem_valid && mem_ready) begin
        n_acc++;
        if (mem_we) begin
          n_wr++;
          mem[mem_addr[7:0]] <= mem_wdata;
          if (qa.size() == 0) check(0, cur_req, "unexpected write addr", int'(mem_addr), -1);
          else begin
            logic [15:0] ea; logic [7:0] ed;
            ea = qa.pop_front(); ed = qd.pop_front();
            check(mem_addr == ea, cur_req, "write addr", int'(mem_addr), int'(ea));
            check(mem_wdata == ed, cur_req, "write data", int'(mem_wdata), int'(ed));
          end
        end else begin
          rd_pend = 1; rd_wait = int'(lfsr[0]); rd_a = mem_addr[7:0];
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready <= lfsr[1] | lfsr[2];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int acc0, wr0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 64; i++) dtab[i] = '0;
    dtab[0]  = mkd(2'd0, 0, 0, 6'd1, 6'd0, 32'h13, 32'h81, 32'd5);
    dtab[1]  = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h20, 32'h90, 32'd1);
    dtab[3]  = mkd(2'd0, 1, 1, 6'd0, 6'd0, 32'h31, 32'hA0, 32'd4);
    dtab[7]  = mkd(2'd0, 0, 0, 6'd8, 6'd0, 32'h60, 32'hFE, 32'd0);
    dtab[8]  = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h05, 32'hC0, 32'd2);
    dtab[9]  = mkd(2'd1, 0, 0, 6'd11, 6'd10, 32'h50, 32'h0F, 32'hFA);
    dtab[10] = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h60, 32'hB0, 32'd1);
    dtab[11] = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h61, 32'hB8, 32'd1);
    dtab[20] = mkd(2'd2, 0, 0, 6'd21, 6'd30, 32'h0, 32'h0, 32'h0);
    dtab[21] = mkd(2'd2, 0, 1, 6'd22, 6'd30, 32'h0, 32'h0, 32'h0);
    dtab[22] = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h44, 32'hD8, 32'd1);
    dtab[30] = mkd(2'd0, 0, 0, 6'd31, 6'd0, 32'h40, 32'hD0, 32'd2);
    dtab[31] = mkd(2'd3, 0, 1, 6'd0, 6'd0, 32'h0, 32'h0, 32'h0);
    dtab[40] = mkd(2'd2, 0, 0, 6'd42, 6'd41, 32'h0, 32'h0, 32'h0);
    dtab[41] = mkd(2'd2, 0, 0, 6'd42, 6'd43, 32'h0, 32'h0, 32'h0);
    dtab[42] = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h01, 32'hF4, 32'd1);
    dtab[43] = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h02, 32'hF5, 32'd1);
    dtab[45] = mkd(2'd3, 0, 1, 6'd0, 6'd0, 32'h0, 32'h0, 32'h0);
    dtab[50] = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h70, 32'hE0, 32'd6);
    dtab[51] = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h00, 32'hF0, 32'd1);
    dtab[55] = mkd(2'd0, 0, 1, 6'd0, 6'd0, 32'h0A, 32'h88, 32'd2);
    dtab[56] = mkd(2'd0, 1, 1, 6'd0, 6'd0, 32'h10, 32'h8C, 32'd3);
    mem[8'h50] = 8'h5A;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err && !mem_valid, "R1", "reset outputs", int'({busy, done, err, mem_valid}), 0);
    rst_n = 1'b1;

    // R2 ascending copy, odd alignment, chained to a second descriptor
    cur_req = "R2"; push_copy(8'h13, 8'h81, 5, 0); push_copy(8'h20, 8'h90, 1, 0);
    run_list(6'd0);
    check(busy_after, "R1", "busy after start", int'(busy_after), 1);
    check(saw_done && !saw_err, "R2", "chain done", int'(saw_done), 1);
    check(qa.size() == 0, "R2", "writes outstanding", qa.size(), 0);

    // R3 reversed copy
    cur_req = "R3"; push_copy(8'h31, 8'hA0, 4, 1);
    run_list(6'd3);
    check(saw_done && qa.size() == 0, "R3", "reverse complete", qa.size(), 0);

    // R4 zero count makes no request
    cur_req = "R4"; push_copy(8'h05, 8'hC0, 2, 0); acc0 = n_acc;
    run_list(6'd7);
    check(n_acc - acc0 == 4, "R4", "request count", n_acc - acc0, 4);

    // R5 compare taken (upper mask bits ignored) then not taken
    cur_req = "R5"; push_copy(8'h60, 8'hB0, 1, 0);
    run_list(6'd9);
    check(saw_done && qa.size() == 0, "R5", "taken branch", qa.size(), 0);
    dtab[9][127:96] = 32'h0B; push_copy(8'h61, 8'hB8, 1, 0);
    run_list(6'd9);
    check(saw_done && qa.size() == 0, "R5", "fall through", qa.size(), 0);

    // R6 call, return, second call after record freed
    cur_req = "R6"; push_copy(8'h40, 8'hD0, 2, 0); push_copy(8'h40, 8'hD0, 2, 0);
    push_copy(8'h44, 8'hD8, 1, 0);
    run_list(6'd20);
    check(saw_done && !saw_err, "R6", "call chain done", int'(saw_done), 1);
    check(qa.size() == 0, "R6", "call writes", qa.size(), 0);

    // R7 nested call, then return with nothing recorded
    cur_req = "R7"; wr0 = n_wr;
    run_list(6'd40);
    check(saw_err && !saw_done, "R7", "nested call fault", int'(saw_err), 1);
    check(n_wr == wr0, "R7", "no writes on fault", n_wr - wr0, 0);
    run_list(6'd45);
    check(!err_after, "R7", "err cleared by start", int'(err_after), 0);
    check(saw_err && !saw_done, "R7", "orphan return fault", int'(saw_err), 1);

    // R1 start while busy is ignored
    cur_req = "R1"; push_copy(8'h70, 8'hE0, 6, 0);
    @(negedge clk); head = 6'd50; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    head = 6'd51; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_end(3000); wr0 = n_wr;
    repeat (20) @(negedge clk);
    check(saw_done && qa.size() == 0, "R1", "first list only", qa.size(), 0);
    check(n_wr == wr0 && !busy, "R1", "no second run", n_wr - wr0, 0);

    // R8 start in the done cycle
    cur_req = "R8"; push_copy(8'h0A, 8'h88, 2, 0); push_copy(8'h10, 8'h8C, 3, 1);
    @(negedge clk); head = 6'd55; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_end(3000);
    check(saw_done && !busy, "R8", "idle in done cycle", int'(busy), 0);
    head = 6'd56; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && !done, "R8", "restart accepted, pulse single", int'({busy, done}), 2);
    wait_end(3000);
    check(saw_done && qa.size() == 0, "R8", "second list", qa.size(), 0);

    // R9 requests held while stalled
    check(hold_bad == 0, "R9", "stalled request changed", hold_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule